// File: doc/BRIEF.md
# Low-Power Mode and Reset Sequencer

This block decides when the processor core, its peripherals and its oscillator receive a clock, and it produces the core's internal reset. Software asks for a low-power mode by writing a two-bit power-control register. Bit 0 requests the idle mode, in which only the core's clock stops. Bit 1 requests the power-down mode, in which the oscillator also stops. An enabled, pending interrupt ends idle. The reset pin ends either mode, but it only turns into an internal reset after it has been held high for a set number of oscillator clocks.

While a low-power mode is active, the block takes over the external bus strobes (address latch strobe and program-store strobe) and the two multiplexed bus ports. The values it forces depend on the mode and on whether code runs from external program memory.

When the reset pin wakes the device from idle, the core clock comes back at once. The core may then run for a short window before the internal reset takes hold. During that window the block blocks internal RAM access, while port writes stay allowed.

Top module: `lpm_ctrl`

## Requirements
- R1: The internal reset rises once the reset pin has been sampled high on RST_MC*CYC_PER_MC consecutive clock edges, and never earlier. It falls at the first clock edge that samples the pin low.
- R2: While the internal reset is active, and directly after it ends, the block is in run mode: core, peripheral and oscillator enables are 1, the RAM block is 0, and the power-control register reads 0.
- R3: In run mode, a write with bit 0 set and bit 1 clear enters idle at that clock edge. In idle the core enable is 0, the peripheral and oscillator enables are 1, and the register reads back the written value.
- R4: In run mode, a write with bit 1 set enters power-down at that clock edge, whatever the value of bit 0. In power-down the core, peripheral and oscillator enables are 0 while the reset pin is low.
- R5: A pending interrupt in idle, with the reset pin low, returns the block to run mode at the next clock edge and clears bit 0.
- R6: In power-down an interrupt has no effect. Only the internal reset leaves this mode.
- R7: A reset pin high in idle opens the wake window at the next edge. In the window the core enable is 1 and the RAM block is 1 until the internal reset takes over. A pulse shorter than the R1 length returns the block to idle. A reset pin and an interrupt in the same cycle open the window; the interrupt is not served.
- R8: In power-down the oscillator enable follows the reset pin within the same cycle.
- R9: In idle the strobes are forced to 1. Port 0 floats and port 2 keeps showing the address exactly when external execution is flagged; otherwise both ports show their latched data.
- R10: In power-down the strobes are forced to 0. Port 0 floats exactly when external execution is flagged, and port 2 always shows its latched data.
- R11: Writes to the power-control register are ignored in idle, in power-down and in the wake window.
- R12: In run mode and in the wake window, no pin override is active (all five override outputs are 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_pin_i | input | 1 | Reset pin level, active high |
| irq_i | input | 1 | Enabled interrupt pending |
| ext_exec_i | input | 1 | 1 when code runs from external program memory |
| pcon_we_i | input | 1 | Power-control register write strobe |
| pcon_wdata_i | input | 2 | Write data: bit 0 idle, bit 1 power-down |
| pcon_o | output | 2 | Power-control register contents |
| int_rst_o | output | 1 | Internal reset |
| cpu_clk_en_o | output | 1 | Core clock enable |
| periph_clk_en_o | output | 1 | Peripheral, timer, serial and interrupt clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| ram_block_o | output | 1 | Internal RAM access inhibit |
| strobe_force_o | output | 1 | Overrides both bus strobes |
| strobe_level_o | output | 1 | Level forced on the strobes |
| p0_float_o | output | 1 | Port 0 released to high impedance |
| p2_force_o | output | 1 | Port 2 source is overridden |
| p2_addr_o | output | 1 | Overridden port 2 source: 1 address, 0 latched data |

## Verification
Two pairs of events can fall in one cycle. The first pair is an interrupt and a rising reset pin while the block is idle; the bench drives both on the same edge and expects the wake window, with the idle bit still set. The second pair is both request bits in a single register write; the bench sweeps all four write values under both program-memory sources and expects power-down whenever bit 1 is set. The bench also sweeps the reset pulse length in idle across the reset threshold and checks whether the block goes back to idle or lands in reset.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   typedef enum logic [1:0] {
      MODE_RUN   = 2'd0,
      MODE_IDLE  = 2'd1,
      MODE_PDOWN = 2'd2,
      MODE_WAKE  = 2'd3
   } lpm_mode_e;

   typedef struct packed {
      logic strobe_force;
      logic strobe_level;
      logic p0_float;
      logic p2_force;
      logic p2_addr;
   } pin_ovr_t;

   localparam int unsigned IDLE_BIT = 0;
   localparam int unsigned PD_BIT   = 1;

endpackage

// File: rtl/lpm_rst_filter.sv
module lpm_rst_filter #(
   parameter int unsigned RST_CLKS = 24
) (
   input  logic clk_i,
   input  logic rst_pin_i,
   output logic int_rst_o
);
   localparam int unsigned CW = $clog2(RST_CLKS + 1);
   localparam logic [CW-1:0] LIMIT = CW'(RST_CLKS);

   logic [CW-1:0] held_q;

   initial begin
      if (RST_CLKS < 2) $error("lpm_rst_filter: RST_CLKS must be at least 2");
   end

   always_ff @(posedge clk_i) begin
      if (!rst_pin_i)          held_q <= '0;
      else if (held_q != LIMIT) held_q <= held_q + 1'b1;
   end

   assign int_rst_o = (held_q == LIMIT);

   // R1: reset cannot appear unless the pin was high at the previous edge
   p_rise_needs_pin_r1: assert property (@(posedge clk_i)
      $rose(int_rst_o) |-> $past(rst_pin_i));
   // R1: a low pin releases reset at the next edge
   p_release_r1: assert property (@(posedge clk_i)
      !rst_pin_i |=> !int_rst_o);

endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
   import lpm_pkg::*;
(
   input  logic      clk_i,
   input  logic      int_rst_i,
   input  logic      rst_pin_i,
   input  logic      irq_i,
   input  logic      pcon_we_i,
   input  logic [1:0] pcon_wdata_i,
   output lpm_mode_e mode_o,
   output logic [1:0] pcon_o
);
   lpm_mode_e  mode_q;
   logic [1:0] pcon_q;

   always_ff @(posedge clk_i) begin
      if (int_rst_i) begin
         mode_q <= MODE_RUN;
         pcon_q <= '0;
      end else begin
         unique case (mode_q)
            MODE_RUN: begin
               if (pcon_we_i) begin
                  pcon_q <= pcon_wdata_i;
                  if (pcon_wdata_i[PD_BIT])        mode_q <= MODE_PDOWN;
                  else if (pcon_wdata_i[IDLE_BIT]) mode_q <= MODE_IDLE;
               end
            end
            MODE_IDLE: begin
               if (rst_pin_i) begin
                  mode_q <= MODE_WAKE;
               end else if (irq_i) begin
                  mode_q           <= MODE_RUN;
                  pcon_q[IDLE_BIT] <= 1'b0;
               end
            end
            MODE_WAKE: begin
               if (!rst_pin_i) mode_q <= MODE_IDLE;
            end
            MODE_PDOWN: begin
               mode_q <= MODE_PDOWN;
            end
            default: mode_q <= MODE_RUN;
         endcase
      end
   end

   assign mode_o = mode_q;
   assign pcon_o = pcon_q;

   p_reset_state_r2: assert property (@(posedge clk_i)
      int_rst_i |=> (mode_q == MODE_RUN && pcon_q == 2'b00));

   p_idle_entry_r3: assert property (@(posedge clk_i) disable iff (int_rst_i)
      (mode_q == MODE_RUN && pcon_we_i && pcon_wdata_i == 2'b01) |=> mode_q == MODE_IDLE);

   p_pd_priority_r4: assert property (@(posedge clk_i) disable iff (int_rst_i)
      (mode_q == MODE_RUN && pcon_we_i && pcon_wdata_i[PD_BIT]) |=> mode_q == MODE_PDOWN);

   p_irq_wake_r5: assert property (@(posedge clk_i) disable iff (int_rst_i)
      (mode_q == MODE_IDLE && irq_i && !rst_pin_i) |=> (mode_q == MODE_RUN && !pcon_q[IDLE_BIT]));

   p_pd_hold_r6: assert property (@(posedge clk_i) disable iff (int_rst_i)
      (mode_q == MODE_PDOWN) |=> mode_q == MODE_PDOWN);

   p_wake_entry_r7: assert property (@(posedge clk_i) disable iff (int_rst_i)
      (mode_q == MODE_IDLE && rst_pin_i) |=> mode_q == MODE_WAKE);

   p_pcon_frozen_r11: assert property (@(posedge clk_i) disable iff (int_rst_i)
      (mode_q == MODE_PDOWN || mode_q == MODE_WAKE) |=> $stable(pcon_q));

endmodule

// File: rtl/lpm_pin_ovr.sv
module lpm_pin_ovr
   import lpm_pkg::*;
#(
   parameter bit PIN_REG = 1'b0
) (
   input  logic      clk_i,
   input  logic      int_rst_i,
   input  lpm_mode_e mode_i,
   input  logic      ext_exec_i,
   output pin_ovr_t  ovr_o
);
   pin_ovr_t ovr_d;

   always_comb begin
      ovr_d = '0;
      unique case (mode_i)
         MODE_IDLE: begin
            ovr_d.strobe_force = 1'b1;
            ovr_d.strobe_level = 1'b1;
            ovr_d.p0_float     = ext_exec_i;
            ovr_d.p2_force     = 1'b1;
            ovr_d.p2_addr      = ext_exec_i;
         end
         MODE_PDOWN: begin
            ovr_d.strobe_force = 1'b1;
            ovr_d.strobe_level = 1'b0;
            ovr_d.p0_float     = ext_exec_i;
            ovr_d.p2_force     = 1'b1;
            ovr_d.p2_addr      = 1'b0;
         end
         default: ovr_d = '0;
      endcase
   end

   generate
      if (PIN_REG) begin : g_reg
         pin_ovr_t ovr_q;
         always_ff @(posedge clk_i) begin
            if (int_rst_i) ovr_q <= '0;
            else           ovr_q <= ovr_d;
         end
         assign ovr_o = ovr_q;
      end else begin : g_comb
         assign ovr_o = ovr_d;
      end
   endgenerate

   // R10: port 2 never shows the address while powered down
   p_pd_p2_data_r10: assert property (@(posedge clk_i) disable iff (int_rst_i)
      (mode_i == MODE_PDOWN && $stable(mode_i)) |-> !ovr_o.p2_addr);

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
   import lpm_pkg::*;
#(
   parameter int unsigned CYC_PER_MC = 12,
   parameter int unsigned RST_MC     = 2,
   parameter bit          PIN_REG    = 1'b0
) (
   input  logic       clk_i,
   input  logic       rst_pin_i,
   input  logic       irq_i,
   input  logic       ext_exec_i,
   input  logic       pcon_we_i,
   input  logic [1:0] pcon_wdata_i,
   output logic [1:0] pcon_o,
   output logic       int_rst_o,
   output logic       cpu_clk_en_o,
   output logic       periph_clk_en_o,
   output logic       osc_en_o,
   output logic       ram_block_o,
   output logic       strobe_force_o,
   output logic       strobe_level_o,
   output logic       p0_float_o,
   output logic       p2_force_o,
   output logic       p2_addr_o
);
   localparam int unsigned RST_CLKS = RST_MC * CYC_PER_MC;

   initial begin
      if (CYC_PER_MC < 1) $error("lpm_ctrl: CYC_PER_MC must be at least 1");
      if (RST_MC < 1)     $error("lpm_ctrl: RST_MC must be at least 1");
   end

   lpm_mode_e mode;
   pin_ovr_t  ovr;

   lpm_rst_filter #(.RST_CLKS(RST_CLKS)) u_filter (
      .clk_i     (clk_i),
      .rst_pin_i (rst_pin_i),
      .int_rst_o (int_rst_o)
   );

   lpm_mode_fsm u_fsm (
      .clk_i        (clk_i),
      .int_rst_i    (int_rst_o),
      .rst_pin_i    (rst_pin_i),
      .irq_i        (irq_i),
      .pcon_we_i    (pcon_we_i),
      .pcon_wdata_i (pcon_wdata_i),
      .mode_o       (mode),
      .pcon_o       (pcon_o)
   );

   lpm_pin_ovr #(.PIN_REG(PIN_REG)) u_pins (
      .clk_i      (clk_i),
      .int_rst_i  (int_rst_o),
      .mode_i     (mode),
      .ext_exec_i (ext_exec_i),
      .ovr_o      (ovr)
   );

   assign cpu_clk_en_o    = (mode == MODE_RUN) || (mode == MODE_WAKE);
   assign periph_clk_en_o = (mode != MODE_PDOWN);
   assign osc_en_o        = (mode != MODE_PDOWN) || rst_pin_i;
   assign ram_block_o     = (mode == MODE_WAKE);

   assign strobe_force_o = ovr.strobe_force;
   assign strobe_level_o = ovr.strobe_level;
   assign p0_float_o     = ovr.p0_float;
   assign p2_force_o     = ovr.p2_force;
   assign p2_addr_o      = ovr.p2_addr;

   // R7: the RAM block is lifted once reset has taken over
   p_block_ends_r7: assert property (@(posedge clk_i)
      int_rst_o |=> !ram_block_o);

   // R12: no strobe override is left while the core runs
   p_run_clean_r12: assert property (@(posedge clk_i) disable iff (int_rst_o)
      (cpu_clk_en_o && $stable(cpu_clk_en_o) && !PIN_REG) |-> !strobe_force_o);

endmodule

// File: tb/lpm_ctrl_test.sv
module lpm_ctrl_test;
   localparam int unsigned CYC  = 2;
   localparam int unsigned RMC  = 2;
   localparam int unsigned RCLK = CYC * RMC;

   localparam int M_RUN = 0, M_IDLE = 1, M_PD = 2, M_WAKE = 3;

   logic       clk = 1'b0;
   logic       rst_pin = 1'b0, irq = 1'b0, ext = 1'b0, we = 1'b0;
   logic [1:0] wd = 2'b00;
   logic [1:0] pcon;
   logic       int_rst, cpu_en, per_en, osc_en, ram_blk;
   logic       s_force, s_lvl, p0f, p2f, p2a;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   lpm_ctrl #(.CYC_PER_MC(CYC), .RST_MC(RMC), .PIN_REG(1'b0)) uut (
      .clk_i(clk), .rst_pin_i(rst_pin), .irq_i(irq), .ext_exec_i(ext),
      .pcon_we_i(we), .pcon_wdata_i(wd), .pcon_o(pcon), .int_rst_o(int_rst),
      .cpu_clk_en_o(cpu_en), .periph_clk_en_o(per_en), .osc_en_o(osc_en),
      .ram_block_o(ram_blk), .strobe_force_o(s_force), .strobe_level_o(s_lvl),
      .p0_float_o(p0f), .p2_force_o(p2f), .p2_addr_o(p2a)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   function automatic logic [3:0] exp_status(int m, logic rp);
      case (m)
         M_RUN:   return 4'b1110;
         M_IDLE:  return 4'b0110;
         M_PD:    return {3'b000, rp} << 1;
         default: return 4'b1111;
      endcase
   endfunction

   function automatic logic [4:0] exp_pins(int m, logic e);
      case (m)
         M_IDLE:  return {1'b1, 1'b1, e, 1'b1, e};
         M_PD:    return {1'b1, 1'b0, e, 1'b1, 1'b0};
         default: return 5'b00000;
      endcase
   endfunction

   task automatic chk_mode(input string req, input int m);
      chk(req, {4'h0, cpu_en, per_en, osc_en, ram_blk}, {4'h0, exp_status(m, rst_pin)});
      chk(req, {3'h0, s_force, s_lvl, p0f, p2f, p2a}, {3'h0, exp_pins(m, ext)});
   endtask

   task automatic do_reset();
      rst_pin = 1'b1; irq = 1'b0; we = 1'b0;
      repeat (RCLK - 1) step();
      chk("R1 early", {7'h0, int_rst}, 8'h00);
      step();
      chk("R1 onset", {7'h0, int_rst}, 8'h01);
      step();
      chk("R2 pcon", {6'h0, pcon}, 8'h00);
      chk_mode("R2 state", M_RUN);
      rst_pin = 1'b0;
      step();
      chk("R1 release", {7'h0, int_rst}, 8'h00);
      chk_mode("R2 after", M_RUN);
   endtask

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      step();
      // mode entry sweep: both program sources, every write value
      for (int e = 0; e < 2; e++) begin
         for (int w = 0; w < 4; w++) begin
            automatic int m;
            do_reset();
            ext = e[0];
            m = w[1] ? M_PD : (w[0] ? M_IDLE : M_RUN);
            we = 1'b1; wd = w[1:0];
            step();
            we = 1'b0;
            #1;
            chk("R3 R4 readback", {6'h0, pcon}, {6'h0, w[1:0]});
            chk_mode(m == M_PD ? "R4 R10 entry" : (m == M_IDLE ? "R3 R9 entry" : "R12 run"), m);
            if (m == M_PD) begin
               irq = 1'b1; step(); irq = 1'b0; #1;
               chk_mode("R6 irq ignored", M_PD);
               we = 1'b1; wd = 2'b00; step(); we = 1'b0; #1;
               chk("R11 pd write", {6'h0, pcon}, {6'h0, w[1:0]});
               rst_pin = 1'b1; #1;
               chk("R8 osc on", {7'h0, osc_en}, 8'h01);
               rst_pin = 1'b0; #1;
               chk("R8 osc off", {7'h0, osc_en}, 8'h00);
            end else if (m == M_IDLE) begin
               we = 1'b1; wd = 2'b10; step(); we = 1'b0; #1;
               chk("R11 idle write", {6'h0, pcon}, 8'h01);
               chk_mode("R11 idle kept", M_IDLE);
               irq = 1'b1; step(); irq = 1'b0; #1;
               chk("R5 bit cleared", {6'h0, pcon}, 8'h00);
               chk_mode("R5 R12 run", M_RUN);
            end
         end
      end
      // wake-window sweep over reset pulse length
      for (int len = 1; len <= RCLK + 1; len++) begin
         do_reset();
         ext = 1'b1;
         we = 1'b1; wd = 2'b01; step(); we = 1'b0;
         rst_pin = 1'b1;
         irq = (len == 1);
         step();
         irq = 1'b0;
         #1;
         chk_mode("R7 R12 window", M_WAKE);
         chk("R7 irq lost", {6'h0, pcon}, 8'h01);
         we = 1'b1; wd = 2'b10;
         for (int k = 2; k <= len; k++) begin
            step();
            we = 1'b0;
            #1;
            chk("R1 in window", {7'h0, int_rst}, {7'h0, k >= RCLK});
            chk_mode("R7 window hold", (k > RCLK) ? M_RUN : M_WAKE);
         end
         we = 1'b0;
         rst_pin = 1'b0;
         step();
         #1;
         if (len < RCLK) begin
            chk("R11 window write", {6'h0, pcon}, 8'h01);
            chk_mode("R7 back to idle", M_IDLE);
         end else begin
            chk("R2 pcon cleared", {6'h0, pcon}, 8'h00);
            chk_mode("R2 reset run", M_RUN);
         end
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule